// File: doc/BRIEF.md
# Per-CPU Interrupt Interface with Inter-Processor Signalling

This block is the interrupt front end that one processor core sees. Each core gets its own instance. It gathers 32 private request lines (IDs 0 to 31) and a set of shared request lines that an upstream router has already steered to this core (IDs 32 and up). It keeps one small state machine per line and raises a single request output towards the core. Software drives it through a word-addressed register window. It enables or disables a line by writing that line's ID. It takes the next interrupt by reading a ready register, and it retires an interrupt by writing the ID back to a completion register.

The private IDs 0 to 15 also act as software-signalled lines between cores. A single write packs a target-core mask and a 4-bit ID. The block sends that write out as a one-cycle message for the neighbouring interfaces. When its own bit in the mask is set, it also raises the ID locally. An external delivery vector carries messages from other cores back in.

Each line runs through four named states. `LN_IDLE` means nothing is latched. `LN_PEND` means an edge event is latched. `LN_SERVE` means the line is claimed. `LN_SERVE_RE` means the line is claimed and another edge has arrived since the claim. The transitions are:
- idle→pend on an edge or message event.
- idle→serve on a claim while a level is active.
- pend→serve on a claim.
- serve→serve_re on an event while in service.
- serve→idle on completion.
- serve→pend on completion when an event arrives in the same cycle.
- serve_re→pend on completion.

Top module: `pcpu_irq_if`

## Requirements
- R1: After reset, all enables are clear, the control bit reads 0, `irq_o` and `ipi_tx_valid` are low, and the ready register (offset 0x6C) reads 0xFFFFFFFF.
- R2: Bit 0 of the control register (offset 0x000) gates `irq_o`. The output is high only when that bit is 1 and at least one line is requesting, enabled and not in service.
- R3: Writing an ID to offset 0xA0 sets that line's enable, and writing it to offset 0xA4 clears it. A disabled line is never reported and never raises `irq_o`.
- R4: Reading offset 0x6C returns the lowest-numbered ID that is requesting, enabled and not in service, zero-extended to 32 bits. It returns 0xFFFFFFFF when no such ID exists.
- R5: A read of offset 0x6C that returns an ID claims that line. The ID is not reported again until its ID is written to offset 0xB4.
- R6: Private line i takes a 2-bit trigger code from bits [2(i mod 16)+1 : 2(i mod 16)]. Lines 0–15 use the word at offset 0x14, and lines 16–31 use the word at offset 0x18. The codes are: 0 = active-high level, 1 = active-low level, 2 = rising edge, 3 = falling edge. The reset code is 0, and both words read back.
- R7: A level line that is still active when it is completed is reported again.
- R8: An edge is latched until it is claimed. An edge that arrives while the line is in service makes the line pending again once it is completed.
- R9: A write to offset 0x60 produces, on the next cycle, a one-cycle `ipi_tx_valid` pulse. It carries `ipi_tx_id` = bits [3:0] and `ipi_tx_mask` = bits [8+NUM_CPU-1:8] of the written data.
- R10: The message ID is latched as an edge event on private line ID, whatever that line's trigger code. This happens when the mask bit at position 8+CPU_ID is set, or when `ipi_rx[ID]` is high for a cycle.
- R11: Shared line k maps to ID 32+k and is an active-high level.
- R12: Writing a completion for a line that is not in service has no effect; a latched edge on that line stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a ready read claims) |
| bus_addr | input | AW | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| prv_irq | input | 32 | Private request lines, IDs 0–31 |
| shr_irq | input | N_SHR | Shared lines routed here, IDs 32 and up |
| ipi_rx | input | 16 | Message events from other cores, one bit per ID |
| ipi_tx_valid | output | 1 | One-cycle message strobe |
| ipi_tx_mask | output | NUM_CPU | Target-core mask of the message |
| ipi_tx_id | output | 4 | ID carried by the message |
| irq_o | output | 1 | Request to the core |

## Verification
The bench builds the block with NUM_CPU=4, CPU_ID=1 and N_SHR=4. With these values, a message mask of 0xA reaches the sender itself while 0x4 does not, so both local delivery and its absence are observable. The four shared lines put IDs 32 to 35 on the same ready path as the private lines. The mix of trigger codes on lines 2, 4 and 20 covers a word boundary in the trigger array, one active-low level, and both edge senses.

// File: rtl/pcpu_irq_pkg.sv
package pcpu_irq_pkg;

    typedef enum logic [1:0] {
        LN_IDLE     = 2'd0,
        LN_PEND     = 2'd1,
        LN_SERVE    = 2'd2,
        LN_SERVE_RE = 2'd3
    } ln_state_t;

    typedef enum logic [1:0] {
        TRG_HIGH = 2'd0,
        TRG_LOW  = 2'd1,
        TRG_RISE = 2'd2,
        TRG_FALL = 2'd3
    } trig_t;

    localparam int N_PRV     = 32;
    localparam int N_MSG     = 16;
    localparam int MSG_IDW   = 4;
    localparam int MASK_LSB  = 8;

    localparam logic [11:0] OFF_CTL   = 12'h000;
    localparam logic [11:0] OFF_TRG_A = 12'h014;
    localparam logic [11:0] OFF_TRG_B = 12'h018;
    localparam logic [11:0] OFF_MSG   = 12'h060;
    localparam logic [11:0] OFF_READY = 12'h06C;
    localparam logic [11:0] OFF_SETEN = 12'h0A0;
    localparam logic [11:0] OFF_CLREN = 12'h0A4;
    localparam logic [11:0] OFF_DONE  = 12'h0B4;

endpackage

// File: rtl/pcpu_irq_line.sv
module pcpu_irq_line
    import pcpu_irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  trig_t trig,
    input  logic  raw,
    input  logic  ev_in,
    input  logic  claim,
    input  logic  done,
    output logic  req,
    output logic  serving
);

    logic      raw_q;
    logic      edge_hit;
    logic      evt;
    logic      lvl_on;
    ln_state_t st, st_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) raw_q <= 1'b0;
        else        raw_q <= raw;
    end

    always_comb begin
        unique case (trig)
            TRG_RISE: edge_hit = raw & ~raw_q;
            TRG_FALL: edge_hit = ~raw & raw_q;
            default:  edge_hit = 1'b0;
        endcase
        evt    = edge_hit | ev_in;
        lvl_on = (trig == TRG_HIGH && raw) || (trig == TRG_LOW && !raw);
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            LN_IDLE:     if (claim) st_nx = LN_SERVE;
                         else if (evt) st_nx = LN_PEND;
            LN_PEND:     if (claim) st_nx = LN_SERVE;
            LN_SERVE:    if (done) st_nx = evt ? LN_PEND : LN_IDLE;
                         else if (evt) st_nx = LN_SERVE_RE;
            LN_SERVE_RE: if (done) st_nx = LN_PEND;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= LN_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        req     = (st == LN_PEND) || (st == LN_IDLE && lvl_on);
        serving = (st == LN_SERVE) || (st == LN_SERVE_RE);
    end

    AST_CLAIM_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        claim |-> req); // R5
    AST_CLAIM_SERVES: assert property (@(posedge clk) disable iff (!rst_n)
        claim |=> serving); // R5
    AST_DONE_IDLE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == LN_PEND && done && !claim) |=> st == LN_PEND); // R12
    AST_REPEND_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == LN_SERVE_RE && done) |=> st == LN_PEND); // R8

endmodule

// File: rtl/pcpu_irq_pick.sv
module pcpu_irq_pick #(
    parameter int N   = 40,
    parameter int IDW = 6
) (
    input  logic [N-1:0]   cand,
    output logic           found,
    output logic [IDW-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) begin
                found = 1'b1;
                idx   = IDW'(i);
            end
        end
    end

    always_comb begin
        if (found === 1'b1 && !$isunknown(cand) && !$isunknown(idx)) begin
            AST_PICK_HIT: assert (cand[idx]); // R4
            AST_PICK_LOWEST: assert ((cand & ~({N{1'b1}} << idx)) == '0); // R4
        end
    end

endmodule

// File: rtl/pcpu_irq_if.sv
module pcpu_irq_if
    import pcpu_irq_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int CPU_ID  = 0,
    parameter int N_SHR   = 8,
    parameter int AW      = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [AW-1:0]      bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [31:0]        prv_irq,
    input  logic [N_SHR-1:0]   shr_irq,
    input  logic [15:0]        ipi_rx,
    output logic               ipi_tx_valid,
    output logic [NUM_CPU-1:0] ipi_tx_mask,
    output logic [3:0]         ipi_tx_id,
    output logic               irq_o
);

    localparam int N_LINE = N_PRV + N_SHR;
    localparam int IDW    = $clog2(N_LINE);

    logic              ctl_en;
    logic [63:0]       trig_cfg;
    logic [N_LINE-1:0] en;
    logic [N_LINE-1:0] req, serving, cand, claim_vec, done_vec, ev_vec;
    logic [N_LINE-1:0] raw_vec;
    logic              found;
    logic [IDW-1:0]    pick_idx;
    logic [IDW-1:0]    wr_id;
    logic              id_ok;
    logic              hit_ctl, hit_trga, hit_trgb, hit_msg, hit_ready;
    logic              hit_seten, hit_clren, hit_done;
    logic [N_MSG-1:0]  self_ev;
    logic [31:0]       ready_val;

    always_comb begin
        hit_ctl   = bus_addr == AW'(OFF_CTL);
        hit_trga  = bus_addr == AW'(OFF_TRG_A);
        hit_trgb  = bus_addr == AW'(OFF_TRG_B);
        hit_msg   = bus_addr == AW'(OFF_MSG);
        hit_ready = bus_addr == AW'(OFF_READY);
        hit_seten = bus_addr == AW'(OFF_SETEN);
        hit_clren = bus_addr == AW'(OFF_CLREN);
        hit_done  = bus_addr == AW'(OFF_DONE);
        wr_id     = bus_wdata[IDW-1:0];
        id_ok     = bus_wdata < 32'(N_LINE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_en   <= 1'b0;
            trig_cfg <= '0;
            en       <= '0;
        end else if (bus_wr) begin
            if (hit_ctl)  ctl_en          <= bus_wdata[0];
            if (hit_trga) trig_cfg[31:0]  <= bus_wdata;
            if (hit_trgb) trig_cfg[63:32] <= bus_wdata;
            if (hit_seten && id_ok) en[wr_id] <= 1'b1;
            if (hit_clren && id_ok) en[wr_id] <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ipi_tx_valid <= 1'b0;
            ipi_tx_mask  <= '0;
            ipi_tx_id    <= '0;
        end else begin
            ipi_tx_valid <= bus_wr && hit_msg;
            if (bus_wr && hit_msg) begin
                ipi_tx_mask <= bus_wdata[MASK_LSB +: NUM_CPU];
                ipi_tx_id   <= bus_wdata[MSG_IDW-1:0];
            end
        end
    end

    always_comb begin
        self_ev = '0;
        if (bus_wr && hit_msg && bus_wdata[MASK_LSB + CPU_ID])
            self_ev[bus_wdata[MSG_IDW-1:0]] = 1'b1;
        ev_vec              = '0;
        ev_vec[N_MSG-1:0]   = self_ev | ipi_rx;
        raw_vec             = {shr_irq, prv_irq};
        cand                = req & en;
        claim_vec           = '0;
        if (bus_rd && hit_ready && found) claim_vec[pick_idx] = 1'b1;
        done_vec            = '0;
        if (bus_wr && hit_done && id_ok) done_vec[wr_id] = 1'b1;
    end

    for (genvar g = 0; g < N_LINE; g++) begin : g_line
        trig_t line_trig;
        if (g < N_PRV) begin : g_prv
            assign line_trig = trig_t'(trig_cfg[2*g +: 2]);
        end else begin : g_shr
            assign line_trig = TRG_HIGH;
        end
        pcpu_irq_line u_line (
            .clk     (clk),
            .rst_n   (rst_n),
            .trig    (line_trig),
            .raw     (raw_vec[g]),
            .ev_in   (ev_vec[g]),
            .claim   (claim_vec[g]),
            .done    (done_vec[g]),
            .req     (req[g]),
            .serving (serving[g])
        );
    end

    pcpu_irq_pick #(.N(N_LINE), .IDW(IDW)) u_pick (
        .cand  (cand),
        .found (found),
        .idx   (pick_idx)
    );

    always_comb begin
        ready_val = found ? 32'(pick_idx) : 32'hFFFF_FFFF;
        irq_o     = ctl_en && found;
        unique case (1'b1)
            hit_ctl:   bus_rdata = {31'd0, ctl_en};
            hit_trga:  bus_rdata = trig_cfg[31:0];
            hit_trgb:  bus_rdata = trig_cfg[63:32];
            hit_ready: bus_rdata = ready_val;
            default:   bus_rdata = '0;
        endcase
    end

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit_ctl && !bus_wdata[0]) |=> !irq_o); // R2
    AST_DISABLED_NOT_PICKED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit_clren && id_ok) |=> !(found && pick_idx == $past(wr_id))); // R3
    AST_ONE_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(claim_vec)); // R5
    AST_MSG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit_msg) |=> (ipi_tx_valid && ipi_tx_id == $past(bus_wdata[3:0]))); // R9
    AST_SERVED_NOT_CAND: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cand & serving) == 0); // R5

endmodule

// File: tb/pcpu_irq_if_test.sv
module pcpu_irq_if_test;

    localparam int NC = 4;
    localparam int ME = 1;
    localparam int NS = 4;
    localparam logic [31:0] NONE = 32'hFFFF_FFFF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0, bus_rd = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [31:0]   prv_irq = '0;
    logic [NS-1:0] shr_irq = '0;
    logic [15:0]   ipi_rx = '0;
    logic          ipi_tx_valid;
    logic [NC-1:0] ipi_tx_mask;
    logic [3:0]    ipi_tx_id;
    logic          irq_o;

    int    n_chk = 0;
    int    n_err = 0;
    bit    fin = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    pcpu_irq_if #(.NUM_CPU(NC), .CPU_ID(ME), .N_SHR(NS), .AW(12)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .prv_irq(prv_irq), .shr_irq(shr_irq), .ipi_rx(ipi_rx),
        .ipi_tx_valid(ipi_tx_valid), .ipi_tx_mask(ipi_tx_mask),
        .ipi_tx_id(ipi_tx_id), .irq_o(irq_o)
    );

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // monitor: pops the scoreboard on every read strobe
    always @(negedge clk) begin
        if (bus_rd) begin
            if (exp_q.size() == 0) begin
                chk("scoreboard empty", 32'd1, 32'd0);
            end else begin
                chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd_at(logic [11:0] a, logic [31:0] exp, string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(posedge clk); #1;
        bus_rd = 1'b1; bus_addr = a;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic rdy(logic [31:0] exp, string tag);
        rd_at(12'h06C, exp, tag);
    endtask

    task automatic setp(int i, logic v);
        @(posedge clk); #1;
        prv_irq[i] = v;
        @(posedge clk); #1;
    endtask

    task automatic pulse(int i);
        @(posedge clk); #1;
        prv_irq[i] = 1'b1;
        @(posedge clk); #1;
        prv_irq[i] = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!fin) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: got hang expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 irq_o at reset", 32'(irq_o), 32'd0);
        chk("R1 ipi_tx_valid at reset", 32'(ipi_tx_valid), 32'd0);
        rd_at(12'h000, 32'd0, "R1 control reads 0");
        rdy(NONE, "R1 ready empty");

        // level lines, lowest-first, claim and completion
        wr(12'h000, 32'd1);
        wr(12'h0A0, 32'd3);
        wr(12'h0A0, 32'd5);
        setp(3, 1'b1);
        setp(5, 1'b1);
        @(negedge clk);
        chk("R2 irq_o with pending", 32'(irq_o), 32'd1);
        rdy(32'd3, "R4 lowest first");
        rdy(32'd5, "R5 claimed 3 hidden");
        rdy(NONE, "R5 both in service");
        wr(12'h0B4, 32'd3);
        rdy(32'd3, "R7 level re-reported");
        setp(3, 1'b0);
        setp(5, 1'b0);
        wr(12'h0B4, 32'd3);
        wr(12'h0B4, 32'd5);
        rdy(NONE, "R4 empty after completion");

        // control gate
        setp(5, 1'b1);
        wr(12'h000, 32'd0);
        @(negedge clk);
        chk("R2 irq_o gated off", 32'(irq_o), 32'd0);
        wr(12'h000, 32'd1);
        @(negedge clk);
        chk("R2 irq_o gated on", 32'(irq_o), 32'd1);
        setp(5, 1'b0);
        @(negedge clk);
        chk("R2 irq_o after level drop", 32'(irq_o), 32'd0);

        // enable and disable by ID
        wr(12'h0A0, 32'd7);
        setp(7, 1'b1);
        wr(12'h0A4, 32'd7);
        @(negedge clk);
        chk("R3 disabled line quiet", 32'(irq_o), 32'd0);
        rdy(NONE, "R3 disabled not reported");
        wr(12'h0A0, 32'd7);
        rdy(32'd7, "R3 re-enabled reported");
        setp(7, 1'b0);
        wr(12'h0B4, 32'd7);

        // trigger codes: line 2 falling, line 4 low level, line 20 rising
        wr(12'h014, 32'h0000_0130);
        wr(12'h018, 32'h0000_0200);
        rd_at(12'h018, 32'h0000_0200, "R6 trigger word readback");
        wr(12'h0A0, 32'd2);
        wr(12'h0A0, 32'd4);
        wr(12'h0A0, 32'd20);
        rdy(32'd4, "R6 active-low level");
        setp(4, 1'b1);
        wr(12'h0B4, 32'd4);
        rdy(NONE, "R6 active-low released");
        pulse(20);
        rdy(32'd20, "R8 rising edge latched");
        rdy(NONE, "R8 edge cleared on claim");
        pulse(20);
        wr(12'h0B4, 32'd20);
        rdy(32'd20, "R8 edge during service re-pends");
        wr(12'h0B4, 32'd20);
        rdy(NONE, "R8 nothing left");
        pulse(20);
        wr(12'h0B4, 32'd20);
        rdy(32'd20, "R12 completion of pending line ignored");
        wr(12'h0B4, 32'd20);
        setp(2, 1'b1);
        rdy(NONE, "R6 rise ignored on falling line");
        setp(2, 1'b0);
        rdy(32'd2, "R6 falling edge");
        wr(12'h0B4, 32'd2);

        // message send: mask 0xA includes CPU 1
        wr(12'h060, 32'h0000_0A0F);
        @(negedge clk);
        chk("R9 tx valid", 32'(ipi_tx_valid), 32'd1);
        chk("R9 tx mask", 32'(ipi_tx_mask), 32'hA);
        chk("R9 tx id", 32'(ipi_tx_id), 32'd15);
        @(negedge clk);
        chk("R9 tx one cycle", 32'(ipi_tx_valid), 32'd0);
        wr(12'h0A0, 32'd15);
        rdy(32'd15, "R10 self delivery");
        wr(12'h0B4, 32'd15);
        wr(12'h0A0, 32'd14);
        wr(12'h060, 32'h0000_040E);
        rdy(NONE, "R10 no self bit no delivery");

        // message receive on a level-coded line
        wr(12'h0A0, 32'd6);
        @(posedge clk); #1 ipi_rx[6] = 1'b1;
        @(posedge clk); #1 ipi_rx[6] = 1'b0;
        rdy(32'd6, "R10 received message");
        rdy(NONE, "R10 message cleared on claim");
        wr(12'h0B4, 32'd6);

        // shared lines
        wr(12'h0A0, 32'd33);
        @(posedge clk); #1 shr_irq[1] = 1'b1;
        rdy(32'd33, "R11 shared line id");
        rdy(NONE, "R11 shared in service");
        wr(12'h0B4, 32'd33);
        rdy(32'd33, "R11 shared level again");
        @(posedge clk); #1 shr_irq[1] = 1'b0;
        wr(12'h0B4, 32'd33);
        rdy(NONE, "R11 shared released");

        repeat (2) @(posedge clk);
        fin = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule